// File: doc/BRIEF.md
# Computational Memory Row Unit

This block models a computational static memory macro with a small operation unit placed behind its sense stage. It has two modes. In normal mode it is a word-addressed memory with one registered read port and one write port. In compute mode it reads two source rows in the same cycle and combines them bit by bit. Every result is derived from the AND, NAND, OR and NOR of the two source bits. The result chosen by a 4-bit opcode is written into a destination row on the clock edge that ends the operation cycle.

A row holds several 32-bit words. A per-word enable vector selects the words that take part in an operation. Each enabled word is computed on its own, so one operation works as a narrow SIMD step. Carries never cross a word boundary. Arithmetic reuses a single generate/propagate carry chain, whose inputs are chosen by multiplexers:
- generate is the AND of the source bits;
- propagate is the XOR of the source bits, formed as the NOR of the AND and NOR results;
- increment, decrement and negation derive generate and propagate from the first operand alone.

A subtraction takes two operations: negate the subtrahend into a scratch row, then add. Copy and invert need no opcodes of their own. They are issued as AND or NAND with both source rows equal.

Top module: `cmem_row_alu`

## Requirements
- R1: In normal mode, a write with `nm_en=1`, `nm_we=1` stores `nm_wdata` in word `nm_col` of row `nm_row`. Word `c` occupies row bits `[32*c+31:32*c]`. A read with `nm_en=1`, `nm_we=0` presents that word on `nm_rdata` after the next rising edge. Reset clears `nm_rdata` to zero.
- R2: While `cmp_mode=0`, the compute inputs have no effect on the array, even with `cm_go=1`.
- R3: While `cmp_mode=1`, the normal-port inputs have no effect. Writes are dropped and `nm_rdata` keeps its value.
- R4: The opcodes AND=0, OR=1, XOR=2, NOR=3 and NAND=4 write the bitwise function of the words in rows `cm_row_a` and `cm_row_b` into row `cm_row_d`. The write lands on the edge that ends the cycle in which `cmp_mode=1` and `cm_go=1`.
- R5: ADD=5 (signed) and ADDU=6 (unsigned) both write A+B modulo 2^32 for each word. No carry passes into the next word.
- R6: NEG=7 writes the two's complement of A, and the negation of 0 is 0. A subtraction A-B is obtained by a NEG into a scratch row followed by an ADD.
- R7: INC=8 writes A+1 and DEC=9 writes A-1, both wrapping modulo 2^32.
- R8: SHL=10 writes A shifted left by one and SHR=11 writes A shifted right by one. Both fill the vacated bit with zero and never move a bit across words.
- R9: Only the words whose bit in `cm_word_en` is set are written. The other words of the destination row keep their value.
- R10: AND with `cm_row_a == cm_row_b` copies the word exactly. NAND with equal source rows writes its exact complement.
- R11: Opcodes 12 to 15 write nothing.
- R12: The destination row may equal a source row. The result is then computed from the contents that row held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_mode | input | 1 | 1 selects compute mode, 0 selects normal mode |
| nm_en | input | 1 | Normal-mode access request |
| nm_we | input | 1 | Normal-mode write (1) or read (0) |
| nm_row | input | 7 | Normal-mode row address |
| nm_col | input | 3 | Normal-mode word index within the row |
| nm_wdata | input | 32 | Normal-mode write data |
| nm_rdata | output | 32 | Registered normal-mode read data |
| cm_go | input | 1 | Start a compute operation this cycle |
| cm_op | input | 4 | Compute opcode |
| cm_row_a | input | 7 | First source row |
| cm_row_b | input | 7 | Second source row |
| cm_row_d | input | 7 | Destination row |
| cm_word_en | input | 8 | Per-word enable for the compute operation |

## Verification
The bench drives carry at the word boundaries:
- an all-ones word plus one, which must wrap to zero without disturbing the next word;
- 0x7FFFFFFF plus one, and a sum of two 0x80000000 words;
- decrement of zero and negation of zero.

A chain that leaked carry between lanes, or that chose the wrong propagate or generate for a single-operand opcode, would corrupt exactly these words.

Shifts of 0x80000000 and of 1 show whether vacated bits are zero-filled. A sparse word-enable pattern shows whether disabled words are overwritten. An update in place, with the destination equal to a source, shows whether the result uses the old row or a half-written one. Further cases check that opcodes above 11 leave the destination unchanged, and that each port stays inert in the other mode.

// File: rtl/cmem_pkg.sv
package cmem_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_NOR  = 4'd3,
    OP_NAND = 4'd4,
    OP_ADD  = 4'd5,
    OP_ADDU = 4'd6,
    OP_NEG  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_SHL  = 4'd10,
    OP_SHR  = 4'd11
  } cm_op_e;

  function automatic logic op_writes(input logic [3:0] op);
    return op <= OP_SHR;
  endfunction

endpackage

// File: rtl/cmem_sense.sv
// Dual-row sense stage for one word: all four two-input results at once.
module cmem_sense #(
  parameter int W = 32
) (
  input  logic [W-1:0] bit_a,
  input  logic [W-1:0] bit_b,
  output logic [W-1:0] s_and,
  output logic [W-1:0] s_nand,
  output logic [W-1:0] s_or,
  output logic [W-1:0] s_nor
);
  assign s_and  = bit_a & bit_b;
  assign s_nand = ~s_and;
  assign s_or   = bit_a | bit_b;
  assign s_nor  = ~s_or;
endmodule

// File: rtl/cmem_lane_alu.sv
// Per-word operation unit behind the sense stage.
module cmem_lane_alu
  import cmem_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] s_and,
  input  logic [W-1:0] s_nand,
  input  logic [W-1:0] s_or,
  input  logic [W-1:0] s_nor,
  output logic [W-1:0] res
);
  logic [W-1:0] s_xor, prop, gen, carry;
  logic         use_chain;

  // XOR is formed from the two sense results, never from the raw bits.
  assign s_xor = ~(s_and | s_nor);

  always_comb begin
    prop      = '0;
    gen       = '0;
    use_chain = 1'b0;
    res       = '0;
    case (op)
      OP_AND:  res = s_and;
      OP_OR:   res = s_or;
      OP_XOR:  res = s_xor;
      OP_NOR:  res = s_nor;
      OP_NAND: res = s_nand;
      OP_ADD, OP_ADDU: begin
        prop = s_xor;
        gen  = s_and;
        use_chain = 1'b1;
      end
      OP_NEG: begin // ~a + 1
        prop = {~opa[W-1:1], opa[0]};
        gen  = {{(W-1){1'b0}}, ~opa[0]};
        use_chain = 1'b1;
      end
      OP_INC: begin // a + 1
        prop = {opa[W-1:1], ~opa[0]};
        gen  = {{(W-1){1'b0}}, opa[0]};
        use_chain = 1'b1;
      end
      OP_DEC: begin // a + all ones
        prop = ~opa;
        gen  = opa;
        use_chain = 1'b1;
      end
      OP_SHL:  res = {opa[W-2:0], 1'b0};
      OP_SHR:  res = {1'b0, opa[W-1:1]};
      default: res = '0;
    endcase

    // Ripple chain; carry into bit 0 is zero and the carry out is dropped.
    carry[0] = 1'b0;
    for (int i = 0; i < W - 1; i++) begin
      carry[i+1] = gen[i] | (prop[i] & carry[i]);
    end
    if (use_chain) res = prop ^ carry;
  end
endmodule

// File: rtl/cmem_row_alu.sv
module cmem_row_alu
  import cmem_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmp_mode,
  input  logic                      nm_en,
  input  logic                      nm_we,
  input  logic [$clog2(ROWS)-1:0]   nm_row,
  input  logic [$clog2(WORDS)-1:0]  nm_col,
  input  logic [WORD_W-1:0]         nm_wdata,
  output logic [WORD_W-1:0]         nm_rdata,
  input  logic                      cm_go,
  input  logic [3:0]                cm_op,
  input  logic [$clog2(ROWS)-1:0]   cm_row_a,
  input  logic [$clog2(ROWS)-1:0]   cm_row_b,
  input  logic [$clog2(ROWS)-1:0]   cm_row_d,
  input  logic [WORDS-1:0]          cm_word_en
);
  localparam int ROW_W = WORD_W * WORDS;

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] src_a_row, src_b_row, lane_res;
  logic             op_ok;

  assign src_a_row = mem[cm_row_a];
  assign src_b_row = mem[cm_row_b];
  assign op_ok     = op_writes(cm_op);

  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    logic [WORD_W-1:0] w_and, w_nand, w_or, w_nor;

    cmem_sense #(.W(WORD_W)) u_sense (
      .bit_a  (src_a_row[g*WORD_W +: WORD_W]),
      .bit_b  (src_b_row[g*WORD_W +: WORD_W]),
      .s_and  (w_and),
      .s_nand (w_nand),
      .s_or   (w_or),
      .s_nor  (w_nor)
    );

    cmem_lane_alu #(.W(WORD_W)) u_alu (
      .op     (cm_op),
      .opa    (src_a_row[g*WORD_W +: WORD_W]),
      .s_and  (w_and),
      .s_nand (w_nand),
      .s_or   (w_or),
      .s_nor  (w_nor),
      .res    (lane_res[g*WORD_W +: WORD_W])
    );
  end

  // Array write: compute write-back or normal write, chosen by mode.
  always_ff @(posedge clk) begin
    if (!rst) begin
      if (cmp_mode) begin
        if (cm_go && op_ok) begin
          for (int w = 0; w < WORDS; w++) begin
            if (cm_word_en[w])
              mem[cm_row_d][w*WORD_W +: WORD_W] <= lane_res[w*WORD_W +: WORD_W];
          end
        end
      end else if (nm_en && nm_we) begin
        mem[nm_row][nm_col*WORD_W +: WORD_W] <= nm_wdata;
      end
    end
  end

  // Registered normal-mode read port.
  always_ff @(posedge clk) begin
    if (rst) begin
      nm_rdata <= '0;
    end else if (!cmp_mode && nm_en && !nm_we) begin
      nm_rdata <= mem[nm_row][nm_col*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/cmem_row_alu_chk.sv
module cmem_row_alu_chk
  import cmem_pkg::*;
#(
  parameter int ROWS   = 128,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmp_mode,
  input logic                     nm_en,
  input logic                     nm_we,
  input logic [$clog2(ROWS)-1:0]  nm_row,
  input logic [$clog2(WORDS)-1:0] nm_col,
  input logic [WORD_W-1:0]        nm_wdata,
  input logic [WORD_W-1:0]        nm_rdata,
  input logic                     cm_go,
  input logic [3:0]               cm_op,
  input logic [$clog2(ROWS)-1:0]  cm_row_a,
  input logic [$clog2(ROWS)-1:0]  cm_row_b,
  input logic [WORD_W*WORDS-1:0]  src_a_row,
  input logic [WORD_W*WORDS-1:0]  src_b_row,
  input logic [WORD_W*WORDS-1:0]  lane_res
);
  p_write_read_r1: assert property (@(posedge clk) disable iff (rst)
    (!cmp_mode && nm_en && nm_we) ##1
    (!cmp_mode && nm_en && !nm_we && nm_row == $past(nm_row) && nm_col == $past(nm_col))
    |=> nm_rdata == $past(nm_wdata, 2));

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
    cmp_mode |=> $stable(nm_rdata));

  p_add_sum_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && cm_go && cm_op == OP_ADDU)
    |-> lane_res[WORD_W-1:0] == src_a_row[WORD_W-1:0] + src_b_row[WORD_W-1:0]);

  p_shl_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && cm_go && cm_op == OP_SHL)
    |-> lane_res[WORD_W-1:0] == {src_a_row[WORD_W-2:0], 1'b0});

  p_copy_r10: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && cm_go && cm_op == OP_AND && cm_row_a == cm_row_b)
    |-> lane_res == src_a_row);

  p_invert_r10: assert property (@(posedge clk) disable iff (rst)
    (cmp_mode && cm_go && cm_op == OP_NAND && cm_row_a == cm_row_b)
    |-> lane_res == ~src_a_row);
endmodule

bind cmem_row_alu cmem_row_alu_chk #(
  .ROWS(ROWS), .WORD_W(WORD_W), .WORDS(WORDS)
) u_chk (
  .clk(clk), .rst(rst), .cmp_mode(cmp_mode), .nm_en(nm_en), .nm_we(nm_we),
  .nm_row(nm_row), .nm_col(nm_col), .nm_wdata(nm_wdata), .nm_rdata(nm_rdata),
  .cm_go(cm_go), .cm_op(cm_op), .cm_row_a(cm_row_a), .cm_row_b(cm_row_b),
  .src_a_row(src_a_row), .src_b_row(src_b_row), .lane_res(lane_res)
);

// File: tb/cmem_row_alu_bench.sv
`timescale 1ns/1ps
module cmem_row_alu_bench;
  localparam int ROWS = 128, WW = 32, WORDS = 8, USED = 64;
  localparam int RA = $clog2(ROWS), CA = $clog2(WORDS);

  logic clk = 1'b0, rst = 1'b1;
  logic cmp_mode = 0, nm_en = 0, nm_we = 0, cm_go = 0;
  logic [RA-1:0] nm_row = '0, cm_row_a = '0, cm_row_b = '0, cm_row_d = '0;
  logic [CA-1:0] nm_col = '0;
  logic [WW-1:0] nm_wdata = '0, nm_rdata;
  logic [3:0] cm_op = '0;
  logic [WORDS-1:0] cm_word_en = '0;

  int checks = 0, failures = 0;
  logic [WW-1:0] sh [USED][WORDS];

  always #10 clk = ~clk;

  cmem_row_alu #(.ROWS(ROWS), .WORD_W(WW), .WORDS(WORDS)) u_cmem_row_alu (
    .clk(clk), .rst(rst), .cmp_mode(cmp_mode), .nm_en(nm_en), .nm_we(nm_we),
    .nm_row(nm_row), .nm_col(nm_col), .nm_wdata(nm_wdata), .nm_rdata(nm_rdata),
    .cm_go(cm_go), .cm_op(cm_op), .cm_row_a(cm_row_a), .cm_row_b(cm_row_b),
    .cm_row_d(cm_row_d), .cm_word_en(cm_word_en)
  );

  function automatic logic [WW-1:0] expect_op(input logic [3:0] op, input logic [WW-1:0] a, b);
    case (op)
      4'd0: return a & b;
      4'd1: return a | b;
      4'd2: return a ^ b;
      4'd3: return ~(a | b);
      4'd4: return ~(a & b);
      4'd5, 4'd6: return a + b;
      4'd7: return 0 - a;
      4'd8: return a + 1;
      4'd9: return a - 1;
      4'd10: return a << 1;
      4'd11: return a >> 1;
      default: return 'x;
    endcase
  endfunction

  task automatic check(input string tag, input logic [WW-1:0] got, exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic nm_write(input int row, col, input logic [WW-1:0] d);
    @(negedge clk);
    nm_en = 1; nm_we = 1; nm_row = RA'(row); nm_col = CA'(col); nm_wdata = d;
    @(negedge clk);
    nm_en = 0; nm_we = 0;
    sh[row][col] = d;
  endtask

  task automatic rd_chk(input string tag, input int row, col, input logic [WW-1:0] exp);
    @(negedge clk);
    nm_en = 1; nm_we = 0; nm_row = RA'(row); nm_col = CA'(col);
    @(negedge clk);
    nm_en = 0;
    check(tag, nm_rdata, exp);
  endtask

  task automatic row_chk(input string tag, input int row);
    for (int c = 0; c < WORDS; c++) rd_chk(tag, row, c, sh[row][c]);
  endtask

  task automatic do_op(input string tag, input logic [3:0] op, input int ra, rb, rd,
                       input logic [WORDS-1:0] en);
    logic [WW-1:0] nxt [WORDS];
    for (int c = 0; c < WORDS; c++)
      nxt[c] = (op < 4'd12 && en[c]) ? expect_op(op, sh[ra][c], sh[rb][c]) : sh[rd][c];
    @(negedge clk);
    cmp_mode = 1; cm_go = 1; cm_op = op; cm_word_en = en;
    cm_row_a = RA'(ra); cm_row_b = RA'(rb); cm_row_d = RA'(rd);
    @(negedge clk);
    cmp_mode = 0; cm_go = 0;
    for (int c = 0; c < WORDS; c++) sh[rd][c] = nxt[c];
    row_chk(tag, rd);
  endtask

  task automatic t_reset;
    check("R1 reset rdata", nm_rdata, '0);
  endtask

  task automatic t_fill_and_read;
    for (int r = 0; r < USED; r++)
      for (int c = 0; c < WORDS; c++)
        nm_write(r, c, (32'h9E3779B9 * (r * WORDS + c + 1)) ^ {r[15:0], 13'd0, c[2:0]});
    row_chk("R1 normal readback", 7);
    row_chk("R1 normal readback", 63);
  endtask

  task automatic t_logic;
    for (int op = 0; op < 5; op++) do_op("R4 logic op", 4'(op), 1, 2, 10 + op, 8'hFF);
  endtask

  task automatic t_add;
    nm_write(3, 0, 32'hFFFFFFFF); nm_write(4, 0, 32'h1);
    nm_write(3, 1, 32'h7FFFFFFF); nm_write(4, 1, 32'h1);
    nm_write(3, 2, 32'h80000000); nm_write(4, 2, 32'h80000000);
    do_op("R5 addu", 4'd6, 3, 4, 20, 8'hFF);
    check("R5 carry into next word", sh[20][1], 32'h80000000);
    do_op("R5 add signed", 4'd5, 3, 4, 21, 8'hFF);
  endtask

  task automatic t_unary;
    nm_write(5, 0, 32'h0); nm_write(5, 1, 32'h1);
    nm_write(5, 2, 32'h80000000); nm_write(5, 3, 32'hFFFFFFFF);
    do_op("R6 neg", 4'd7, 5, 5, 22, 8'hFF);
    rd_chk("R6 neg zero", 22, 0, 32'h0);
    do_op("R7 inc", 4'd8, 5, 5, 25, 8'hFF);
    rd_chk("R7 inc wrap", 25, 3, 32'h0);
    do_op("R7 dec", 4'd9, 5, 5, 26, 8'hFF);
    rd_chk("R7 dec wrap", 26, 0, 32'hFFFFFFFF);
    do_op("R8 shl", 4'd10, 5, 5, 27, 8'hFF);
    rd_chk("R8 shl msb out", 27, 2, 32'h0);
    do_op("R8 shr", 4'd11, 5, 5, 28, 8'hFF);
    rd_chk("R8 shr lsb out", 28, 1, 32'h0);
  endtask

  task automatic t_sub;
    logic [WW-1:0] diff [WORDS];
    for (int c = 0; c < WORDS; c++) diff[c] = sh[40][c] - sh[41][c];
    do_op("R6 negate subtrahend", 4'd7, 41, 41, 42, 8'hFF);
    do_op("R6 add negated", 4'd5, 40, 42, 43, 8'hFF);
    for (int c = 0; c < WORDS; c++) rd_chk("R6 subtract", 43, c, diff[c]);
  endtask

  task automatic t_mask;
    do_op("R9 word enable", 4'd1, 1, 2, 30, 8'b1010_0101);
  endtask

  task automatic t_copy_not;
    logic [WW-1:0] orig [WORDS];
    for (int c = 0; c < WORDS; c++) orig[c] = sh[6][c];
    do_op("R10 copy", 4'd0, 6, 6, 31, 8'hFF);
    for (int c = 0; c < WORDS; c++) check("R10 copy exact", sh[31][c], orig[c]);
    do_op("R10 not", 4'd4, 6, 6, 32, 8'hFF);
    rd_chk("R10 not exact", 32, 5, ~orig[5]);
  endtask

  task automatic t_bad_op;
    for (int op = 12; op < 16; op++) do_op("R11 unused opcode", 4'(op), 1, 2, 33, 8'hFF);
  endtask

  task automatic t_inplace;
    do_op("R12 in place", 4'd5, 8, 9, 8, 8'hFF);
  endtask

  task automatic t_ignore_compute;
    @(negedge clk);
    cmp_mode = 0; cm_go = 1; cm_op = 4'd0; cm_word_en = 8'hFF;
    cm_row_a = RA'(1); cm_row_b = RA'(2); cm_row_d = RA'(34);
    @(negedge clk);
    cm_go = 0;
    row_chk("R2 compute ignored in normal mode", 34);
  endtask

  task automatic t_ignore_normal;
    logic [WW-1:0] held;
    rd_chk("R3 setup read", 35, 2, sh[35][2]);
    held = sh[35][2];
    @(negedge clk);
    cmp_mode = 1; cm_go = 0; nm_en = 1; nm_we = 1;
    nm_row = RA'(35); nm_col = CA'(2); nm_wdata = ~held;
    @(negedge clk);
    nm_we = 0; nm_row = RA'(36); nm_col = CA'(1);
    @(negedge clk);
    check("R3 rdata held in compute mode", nm_rdata, held);
    nm_en = 0; cmp_mode = 0;
    rd_chk("R3 write dropped in compute mode", 35, 2, held);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 0;
    t_fill_and_read;
    t_logic;
    t_add;
    t_unary;
    t_sub;
    t_mask;
    t_copy_not;
    t_bad_op;
    t_inplace;
    t_ignore_compute;
    t_ignore_normal;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule